// File: doc/BRIEF.md
# Two-Phase Write Permission Guard

This block sits between a CPU write strobe and the write enables of protected memory and I/O. A write only reaches its target if software first armed it with an output cycle to one dedicated permit port, and the write falls inside a fixed window of clock cycles after that arming cycle. Each arming admits exactly one protected write. The permit port itself has no target, is never protected, and the data written to it carries no meaning.

Two kinds of misuse count as protection violations. One is a protected write with no pending permission. The other is a permission that runs out unused. Either one suppresses the offending strobe where one exists, raises a registered non-maskable interrupt pulse of fixed length, and advances a saturating violation counter. A memory write that the caller decodes as falling in the stack and scratch RAM region is exempt, because stack traffic cannot be armed in advance. Such a write passes straight through and never touches the permission state.

Top module: `wr_permit_guard`

## Requirements
- R1: After reset, both write strobes and the NMI output are low, the violation counter reads 0, and no permission is pending.
- R2: A strobe with is_io=1 and addr equal to PERMIT_ADDR (default 16'h00F0) drives neither output strobe, never counts as a violation, and grants one pending permission.
- R3: Once permission is granted, a protected write (any other I/O write, or a memory write with stack_hit=0) in any of the WINDOW (default 64) cycles following the grant cycle is passed to its output strobe in the same cycle: mem_wr_o for is_io=0, io_wr_o for is_io=1.
- R4: If no protected write and no new grant arrives by the last cycle of the window, the permission lapses and nmi_o is high from the next cycle on.
- R5: A protected write with no pending permission drives no output strobe, and nmi_o is high from the next cycle on.
- R6: A memory write (is_io=0) with stack_hit=1 drives mem_wr_o in the same cycle regardless of permission. It neither consumes nor affects a pending permission and never causes a violation.
- R7: A pending permission is consumed by the first protected write. A following protected write needs a new grant, or it is treated as in R5.
- R8: A grant while permission is already pending restarts the full WINDOW-cycle window and raises no violation.
- R9: nmi_o stays high for exactly NMI_LEN (default 4) cycles after the latest violation. A new violation inside the pulse restarts the count.
- R10: viol_cnt_o increments by one for each violation and holds at all ones once saturated.
- R11: I/O writes to any port other than the permit port, the page-select port among them, are protected like memory, and stack_hit has no effect on I/O writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | CPU write strobe, one cycle per write |
| is_io | input | 1 | 1 = I/O port write, 0 = memory write |
| addr | input | ADDR_W | Write address or port number |
| stack_hit | input | 1 | Address falls in the exempt stack/scratch RAM |
| mem_wr_o | output | 1 | Gated memory write strobe |
| io_wr_o | output | 1 | Gated I/O write strobe |
| nmi_o | output | 1 | Violation interrupt pulse |
| viol_cnt_o | output | CNT_W | Saturating violation count |

## Verification
The bench keeps the default 64-cycle window and 4-cycle NMI pulse, so it walks permissions out to exactly the last allowed cycle and one cycle past it. It narrows the counter to CNT_W=3, which puts saturation within reach after a short burst of unarmed writes. A random phase then mixes grants, stack writes, page-port writes and idle gaps, and a cycle model built from the requirements follows every output.

// File: rtl/wr_permit_guard.sv
module wr_permit_guard #(
  parameter int ADDR_W      = 16,
  parameter int PERMIT_ADDR = 16'h00F0,
  parameter int WINDOW      = 64,
  parameter int NMI_LEN     = 4,
  parameter int CNT_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic              is_io,
  input  logic [ADDR_W-1:0] addr,
  input  logic              stack_hit,
  output logic              mem_wr_o,
  output logic              io_wr_o,
  output logic              nmi_o,
  output logic [CNT_W-1:0]  viol_cnt_o
);
  localparam int TW = $clog2(WINDOW + 1);
  localparam int NW = $clog2(NMI_LEN + 1);

  logic          armed;
  logic [TW-1:0] tmr;
  logic [NW-1:0] nmi_left;

  logic permit_req, exempt, prot, expire, viol;

  assign permit_req = wr_stb & is_io & (addr == ADDR_W'(PERMIT_ADDR));
  assign exempt     = wr_stb & ~is_io & stack_hit;
  assign prot       = wr_stb & ~permit_req & ~exempt;
  assign expire     = armed & (tmr == TW'(1)) & ~prot & ~permit_req;
  assign viol       = (prot & ~armed) | expire;

  assign mem_wr_o = exempt | (prot & ~is_io & armed);
  assign io_wr_o  = prot & is_io & armed;
  assign nmi_o    = (nmi_left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed <= 1'b0;
      tmr   <= '0;
    end else if (permit_req) begin
      armed <= 1'b1;
      tmr   <= TW'(WINDOW);
    end else if (prot || expire) begin
      armed <= 1'b0;
      tmr   <= '0;
    end else if (armed) begin
      tmr   <= tmr - TW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              nmi_left <= '0;
    else if (viol)           nmi_left <= NW'(NMI_LEN);
    else if (nmi_left != '0) nmi_left <= nmi_left - NW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                         viol_cnt_o <= '0;
    else if (viol && viol_cnt_o != '1)  viol_cnt_o <= viol_cnt_o + CNT_W'(1);
  end
endmodule

module wr_permit_guard_chk #(
  parameter int ADDR_W      = 16,
  parameter int PERMIT_ADDR = 16'h00F0,
  parameter int WINDOW      = 64,
  parameter int CNT_W       = 8,
  parameter int TW          = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_stb,
  input logic              is_io,
  input logic [ADDR_W-1:0] addr,
  input logic              stack_hit,
  input logic              mem_wr_o,
  input logic              io_wr_o,
  input logic              nmi_o,
  input logic [CNT_W-1:0]  viol_cnt_o,
  input logic              armed,
  input logic [TW-1:0]     tmr
);
  logic is_permit, is_exempt, is_prot;
  assign is_permit = wr_stb && is_io && addr == ADDR_W'(PERMIT_ADDR);
  assign is_exempt = wr_stb && !is_io && stack_hit;
  assign is_prot   = wr_stb && !is_permit && !is_exempt;

  p_permit_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_permit |-> !mem_wr_o && !io_wr_o);

  p_window_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> tmr != '0 && tmr <= TW'(WINDOW));

  p_lapse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed && tmr == TW'(1) && !wr_stb |=> nmi_o);

  p_unarmed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    is_prot && !mem_wr_o && !io_wr_o |=> nmi_o);

  p_stack_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    is_exempt |-> mem_wr_o && !io_wr_o);

  p_single_use_r7: assert property (@(posedge clk) disable iff (!rst_n)
    is_prot && (mem_wr_o || io_wr_o) |=> !(is_prot && (mem_wr_o || io_wr_o)));

  p_nmi_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_o) |=> nmi_o);

  p_cnt_monotone_r10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> viol_cnt_o >= $past(viol_cnt_o));

  p_io_not_exempt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    io_wr_o |-> wr_stb && is_io && !is_permit);
endmodule

bind wr_permit_guard wr_permit_guard_chk #(
  .ADDR_W(ADDR_W), .PERMIT_ADDR(PERMIT_ADDR), .WINDOW(WINDOW), .CNT_W(CNT_W), .TW(TW)
) u_chk (.*);

// File: tb/wr_permit_guard_tb.sv
module wr_permit_guard_tb;
  localparam int ADDR_W = 16;
  localparam int PERMIT = 16'h00F0;
  localparam int PAGE   = 16'h0010;
  localparam int WINDOW = 64;
  localparam int NMIL   = 4;
  localparam int CNT_W  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_stb = 1'b0, is_io = 1'b0, stack_hit = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic mem_wr_o, io_wr_o, nmi_o;
  logic [CNT_W-1:0] viol_cnt_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  bit e_armed = 0;
  int e_left = 0, e_nmi = 0, e_cnt = 0;

  always #4 clk = ~clk;

  wr_permit_guard #(.ADDR_W(ADDR_W), .PERMIT_ADDR(PERMIT), .WINDOW(WINDOW),
                    .NMI_LEN(NMIL), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .is_io(is_io), .addr(addr),
    .stack_hit(stack_hit), .mem_wr_o(mem_wr_o), .io_wr_o(io_wr_o),
    .nmi_o(nmi_o), .viol_cnt_o(viol_cnt_o));

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit f_permit(bit s, bit io, int a);
    return s && io && a == PERMIT;
  endfunction
  function automatic bit f_exempt(bit s, bit io, bit st);
    return s && !io && st;
  endfunction

  task automatic cyc(string tag, bit s, bit io, int a, bit st);
    bit pr, ex, pt, exp_mem, exp_io, v;
    @(negedge clk);
    wr_stb = s; is_io = io; addr = ADDR_W'(a); stack_hit = st;
    #1;
    pr = f_permit(s, io, a);
    ex = f_exempt(s, io, st);
    pt = s && !pr && !ex;
    exp_mem = ex || (pt && !io && e_armed);
    exp_io  = pt && io && e_armed;
    chk(tag, "mem_wr_o", mem_wr_o, exp_mem);
    chk(tag, "io_wr_o",  io_wr_o,  exp_io);
    chk(tag, "nmi_o",    nmi_o,    e_nmi != 0);
    chk(tag, "viol_cnt_o", viol_cnt_o, e_cnt);
    v = pt && !e_armed;
    if (pr) begin
      e_armed = 1; e_left = WINDOW;
    end else if (e_armed) begin
      if (pt) e_armed = 0;
      else if (e_left == 1) begin e_armed = 0; v = 1; end
      else e_left--;
    end
    if (v) e_nmi = NMIL; else if (e_nmi > 0) e_nmi--;
    if (v && e_cnt < (1 << CNT_W) - 1) e_cnt++;
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    chk("R1", "mem_wr_o", mem_wr_o, 0);
    chk("R1", "io_wr_o", io_wr_o, 0);
    chk("R1", "nmi_o", nmi_o, 0);
    chk("R1", "viol_cnt_o", viol_cnt_o, 0);
    rst_n = 1'b1;
    idle("R1", 2);
    // R5: unarmed memory write blocked, nmi for 4 cycles (R9)
    cyc("R5", 1, 0, 16'h4000, 0);
    idle("R9", 6);
    // R2 + R3: grant then memory write
    cyc("R2", 1, 1, PERMIT, 0);
    cyc("R3", 1, 0, 16'h4001, 0);
    // R7: second write without new grant
    cyc("R7", 1, 0, 16'h4002, 0);
    idle("R7", 6);
    // R3 boundary: write on last window cycle
    cyc("R2", 1, 1, PERMIT, 0);
    idle("R3", WINDOW - 1);
    cyc("R3", 1, 1, PAGE, 0);
    idle("R3", 3);
    // R4: lapse one cycle later
    cyc("R2", 1, 1, PERMIT, 0);
    idle("R4", WINDOW);
    cyc("R4", 1, 0, 16'h4003, 0);
    idle("R4", 6);
    // R6: stack writes pass and keep permission intact
    cyc("R6", 1, 0, 16'h8000, 1);
    cyc("R2", 1, 1, PERMIT, 0);
    cyc("R6", 1, 0, 16'h8001, 1);
    cyc("R6", 1, 0, 16'h8002, 1);
    cyc("R11", 1, 1, PAGE, 1);
    cyc("R11", 1, 1, PAGE, 1);
    idle("R11", 6);
    // R8: re-grant restarts window
    cyc("R2", 1, 1, PERMIT, 0);
    idle("R8", 40);
    cyc("R8", 1, 1, PERMIT, 0);
    idle("R8", WINDOW - 1);
    cyc("R8", 1, 0, 16'h4004, 0);
    // R9 restart: violations back to back, then R10 saturation
    for (int i = 0; i < 9; i++) cyc("R10", 1, 1, 16'h0020 + i, 0);
    idle("R9", 6);
    chk("R10", "saturated count", viol_cnt_o, 7);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom_range(0, 99);
      int a;
      bit io = $urandom_range(0, 1);
      if (r < 70) begin idle("R3", 1); continue; end
      if (r < 80) a = PERMIT; else if (r < 88) a = PAGE; else a = $urandom_range(0, 16'hFFFF);
      cyc("R11", 1, io, a, $urandom_range(0, 1));
    end
    done = 1;
  end

  initial begin
    void'($urandom(32'h5EED));
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R1 watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule